// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block sits between a clocked system and an external 32K x 8 asynchronous static RAM that has 15 address lines, one shared 8-bit data bus, and active-low chip enable, output enable and write enable. Each accepted system request becomes one strobe sequence on the memory pins. A read holds chip enable and output enable low until the access time has passed, then captures the byte on a clock edge. A write pulses write enable low while the controller drives the data, and ends on write enable rising while chip enable is still held low.

The system side uses a valid/ready handshake. A request carries an address, a write flag and write data, and is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. Read results come back as a one-cycle `rsp_valid` pulse with the captured byte. Between accesses the memory is deselected, so it sits in standby. After every read the controller waits, with both strobes released, for the memory's bus-release time before it can drive the data bus again.

The wait-state counts are worked out at elaboration from the clock period and from the memory's access, write-pulse, data-setup, cycle and bus-release times. Each count is the time divided by the clock period, rounded up, with a minimum of one cycle. The data bus is split into an output, an output enable and an input, ready for a pad cell.

Top module: `sram_bus_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` and `rsp_valid` are 0, and `cmd_ready` is 1.
- R2: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for the read wait count (2 cycles with the default timing, which is at least 25 ns). It captures `mem_din` on the edge that closes that count, and `rsp_valid` is high in the cycle after that edge, which is the second edge after acceptance with the default timing. `rsp_rdata` then equals the byte stored at the address.
- R3: A write holds `mem_oe_n`=1 throughout and drives `mem_we_n`=0 for the write-pulse count (1 cycle, at least 15 ns, by default). It then spends one cycle with `mem_we_n`=1 and `mem_ce_n`=0, so the write ends on `mem_we_n` rising while `mem_ce_n` is still 0. The byte and address stored are the ones given with the request.
- R4: `mem_dout_en` is 1 only while `mem_oe_n`=1 and `mem_ce_n`=0. `mem_oe_n` and `mem_we_n` are never both 0.
- R5: After a read, the controller keeps `mem_oe_n`=1 and `mem_ce_n`=1 for the turnaround count (1 cycle by default). By default, a request that waits behind a read is accepted 4 edges after the read's acceptance. When `mem_dout_en` rises, `mem_oe_n` has already been 1 for at least the 12 ns release time.
- R6: While no access is in progress (`cmd_ready`=1), `mem_ce_n` is 1.
- R7: `mem_addr` is latched on acceptance. It stays stable, and equal to the accepted address, for as long as `mem_ce_n` is 0, whatever `cmd_addr` does meanwhile.
- R8: `cmd_ready` is 1 only between accesses. A request held valid while `cmd_ready` is 0 is accepted exactly once, when ready returns. By default, a request waiting behind a write is accepted 3 edges after the write's acceptance.
- R9: `rsp_valid` pulses for exactly one cycle per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Controller can take a request this cycle |
| cmd_write | input | 1 | 1 = write request, 0 = read request |
| cmd_addr | input | 15 | Word address of the request |
| cmd_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 15 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dout | output | 8 | Data driven to the memory bus |
| mem_dout_en | output | 1 | Enable for the controller's data drivers |
| mem_din | input | 8 | Data read from the memory bus |

## Verification
With the default timing, a read's byte is due in the cycle after the second edge that follows acceptance. The next waiting request is accepted on the fourth edge after a read and on the third edge after a write. A write lands on the rising edge of `mem_we_n`, one edge after acceptance. The bench stamps every acceptance with a cycle number and stores the due cycle of each read next to its expected byte. The monitor samples on falling clock edges and compares both the value and the cycle in which `rsp_valid` appears. A behavioural memory model measures the strobe windows in nanoseconds at the pin transitions, independently of the clock count.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the asynchronous SRAM
// controller. Assumes all times are given in picoseconds.
package sram_ctrl_pkg;

    // Access sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WEND
    } seq_state_t;

    // Memory pin strobe set, registered as one unit
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dout_en;
    } strobe_t;

    // Clock cycles needed to cover a time, rounded up, at least one
    function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    // Larger of two counts
    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
// Wait-state down counter. Loaded with (cycles - 1) when a phase starts;
// done is high in the last cycle of the phase. Assumes the loader never
// loads a value wider than CNT_W bits.
module sram_wait_timer #(
    parameter int CNT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Access sequencer. Accepts one request between accesses, walks the
// read or write strobe sequence, and inserts a bus turnaround after
// every read. Strobes are registered from the next state so the memory
// pins never glitch. Assumes the timer is loaded only here.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CNT   = 2,
    parameter int unsigned WE_CNT   = 1,
    parameter int unsigned TURN_CNT = 1,
    parameter int          CNT_W    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic             timer_done,
    output logic             cmd_ready,
    output logic             accept,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             cap_en,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dout_en
);

    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CNT - 1);
    localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CNT - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CNT - 1);
    localparam strobe_t STB_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dout_en: 1'b0};

    seq_state_t state_q, state_nxt;
    strobe_t    strb_q;

    // Pin levels that belong to each state
    function automatic strobe_t strobes_for(input seq_state_t s);
        strobe_t r;
        r = STB_IDLE;
        case (s)
            ST_READ:   begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
            ST_WPULSE: begin r.ce_n = 1'b0; r.we_n = 1'b0; r.dout_en = 1'b1; end
            ST_WEND:   begin r.ce_n = 1'b0; r.dout_en = 1'b1; end
            default:   r = STB_IDLE;
        endcase
        return r;
    endfunction

    // Next-state, timer load and capture decisions
    always_comb begin
        state_nxt = state_q;
        accept    = 1'b0;
        load      = 1'b0;
        load_val  = '0;
        cap_en    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (cmd_write) begin
                        state_nxt = ST_WPULSE;
                        load_val  = WE_LD;
                    end else begin
                        state_nxt = ST_READ;
                        load_val  = RD_LD;
                    end
                end
            end
            ST_READ: begin
                if (timer_done) begin
                    cap_en    = 1'b1;
                    load      = 1'b1;
                    load_val  = TURN_LD;
                    state_nxt = ST_TURN;
                end
            end
            ST_TURN:   if (timer_done) state_nxt = ST_IDLE;
            ST_WPULSE: if (timer_done) state_nxt = ST_WEND;
            ST_WEND:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State and registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            strb_q  <= STB_IDLE;
        end else begin
            state_q <= state_nxt;
            strb_q  <= strobes_for(state_nxt);
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign ce_n      = strb_q.ce_n;
    assign oe_n      = strb_q.oe_n;
    assign we_n      = strb_q.we_n;
    assign dout_en   = strb_q.dout_en;

    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (!ce_n && !oe_n && we_n)); // R2
    AST_NO_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n)); // R4
    AST_WRITE_ENDS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !ce_n); // R3
    AST_DRIVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (oe_n && !ce_n)); // R4
    AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(oe_n)); // R5
    AST_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> ce_n); // R6

endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
// Address, write data and read data registers. Latches the request on
// acceptance and captures the memory bus on the capture strobe, raising
// the response pulse for one cycle. Assumes accept and cap_en never
// coincide.
module sram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              ce_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;

    // Hold the request fields for the whole access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

    // Capture the read byte and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= cap_en;
            if (cap_en) begin
                rdata_q <= mem_din;
            end
        end
    end

    assign mem_addr  = addr_q;
    assign mem_dout  = wdata_q;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr_q)); // R7
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_q |=> !rsp_q); // R9

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM controller. Derives wait-state counts from
// the clock period and memory timing, then wires the sequencer, timer and
// datapath. Assumes the memory's own timing is no slower than the
// parameters given here.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W    = 15,
    parameter int          DATA_W    = 8,
    parameter int unsigned CLK_PS    = 20000,
    parameter int unsigned T_ACC_PS  = 25000,
    parameter int unsigned T_CYC_PS  = 25000,
    parameter int unsigned T_WP_PS   = 15000,
    parameter int unsigned T_DS_PS   = 12000,
    parameter int unsigned T_REL_PS  = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int unsigned CYC_CNT  = wait_cycles(T_CYC_PS, CLK_PS);
    localparam int unsigned RD_CNT   = max_u(wait_cycles(T_ACC_PS, CLK_PS), CYC_CNT);
    localparam int unsigned WE_CNT   = max_u(max_u(wait_cycles(T_WP_PS, CLK_PS),
                                                   wait_cycles(T_DS_PS, CLK_PS)),
                                             (CYC_CNT > 1) ? CYC_CNT - 1 : 1);
    localparam int unsigned TURN_CNT = wait_cycles(T_REL_PS, CLK_PS);
    localparam int unsigned CNT_MAX  = max_u(max_u(RD_CNT, WE_CNT), TURN_CNT);
    localparam int          CNT_W    = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

    logic             accept;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             timer_done;
    logic             cap_en;

    sram_seq_fsm #(
        .RD_CNT   (RD_CNT),
        .WE_CNT   (WE_CNT),
        .TURN_CNT (TURN_CNT),
        .CNT_W    (CNT_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .timer_done (timer_done),
        .cmd_ready  (cmd_ready),
        .accept     (accept),
        .load       (load),
        .load_val   (load_val),
        .cap_en     (cap_en),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dout_en    (mem_dout_en)
    );

    sram_wait_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .done     (timer_done)
    );

    sram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cap_en    (cap_en),
        .mem_din   (mem_din),
        .ce_n      (mem_ce_n),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: tb/test_sram_bus_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected reads and writes into
// queues; a falling-edge monitor and a pin-level memory model pop and
// compare them.
module test_sram_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [14:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [7:0]  mem_dout;
    logic        mem_dout_en;
    logic [7:0]  mem_din;

    typedef struct packed { logic [7:0] data; logic [31:0] due; } rd_exp_t;
    typedef struct packed { logic [14:0] addr; logic [7:0] data; } wr_exp_t;

    rd_exp_t    rdq[$];
    wr_exp_t    wrq[$];
    logic [7:0] model_mem [int];
    logic [7:0] shadow [int];
    int         model_gen = 0;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    int         viol_r4 = 0;
    int         viol_r7 = 0;
    int         last_acc = 0;
    bit         last_wr = 1'b0;
    bit         finished = 1'b0;
    logic [14:0] cur_addr = '0;
    realtime    t_we_fall = 0.0;
    realtime    t_oe_rise = 0.0;
    realtime    t_oe_fall = 0.0;

    sram_bus_ctrl i_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] dflt(input logic [14:0] a);
        return a[7:0] ^ {a[14:11], a[3:0]} ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: read path
    always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or model_gen) begin
        if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
            mem_din = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_din = 8'h00;
    end

    always @(negedge mem_we_n) t_we_fall = $realtime;
    always @(posedge mem_oe_n) t_oe_rise = $realtime;
    always @(negedge mem_oe_n) t_oe_fall = $realtime;

    // Memory model: write ends on WE rising while selected
    always @(posedge mem_we_n) begin
        if (rst_n === 1'b1 && mem_ce_n === 1'b0) begin
            wr_exp_t w;
            chk(mem_oe_n === 1'b1 && mem_dout_en === 1'b1, "R3", "strobes at write end",
                {mem_oe_n, mem_dout_en}, 2'b11);
            chk($realtime - t_we_fall >= 15.0, "R3", "WE pulse ns",
                int'($realtime - t_we_fall), 15);
            if (wrq.size() == 0) begin
                chk(1'b0, "R9", "unexpected write", int'(mem_addr), 0);
            end else begin
                w = wrq.pop_front();
                chk(mem_addr == w.addr && mem_dout == w.data, "R3", "written addr/data",
                    {mem_addr, mem_dout}, {w.addr, w.data});
            end
            model_mem[int'(mem_addr)] = mem_dout;
            model_gen++;
        end
    end

    always @(posedge mem_dout_en) begin
        if (rst_n === 1'b1)
            chk(mem_oe_n === 1'b1 && ($realtime - t_oe_rise) >= 12.0, "R5",
                "OE released before drive ns", int'($realtime - t_oe_rise), 12);
    end

    always @(posedge rsp_valid) begin
        if (rst_n === 1'b1)
            chk(($realtime - t_oe_fall) >= 25.0, "R2", "read window ns",
                int'($realtime - t_oe_fall), 25);
    end

    // Monitor: responses and per-cycle pin rules
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dout_en && (mem_oe_n || mem_ce_n) !== 1'b0 && mem_oe_n !== 1'b1) viol_r4++;
            if (mem_dout_en && mem_ce_n) viol_r4++;
            if (!mem_oe_n && !mem_we_n) viol_r4++;
            if (!mem_ce_n && mem_addr !== cur_addr) viol_r7++;
            if (rsp_valid) begin
                if (rdq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected response", rsp_rdata, 0);
                end else begin
                    rd_exp_t e;
                    e = rdq.pop_front();
                    chk(rsp_rdata == e.data, "R2", "read data", rsp_rdata, e.data);
                    chk(cyc == int'(e.due), "R2", "response cycle", cyc, int'(e.due));
                end
            end
        end
    end

    // Driver: present a request, hold it until taken, push expectations
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d,
                         input bit chk_gap);
        int acc;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        while (cmd_ready !== 1'b1) @(negedge clk);
        cur_addr = a;
        acc = cyc + 1;
        if (chk_gap) begin
            if (last_wr) chk(acc - last_acc == 3, "R8", "gap after write", acc - last_acc, 3);
            else         chk(acc - last_acc == 4, "R5", "gap after read", acc - last_acc, 4);
        end
        if (wr) begin
            wrq.push_back('{addr: a, data: d});
            shadow[int'(a)] = d;
        end else begin
            rdq.push_back('{data: shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a),
                            due: 32'(acc + 2)});
        end
        last_acc = acc;
        last_wr  = wr;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr  = ~a;
        cmd_wdata = ~d;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dout_en && !rsp_valid, "R1", "drive/resp", {mem_dout_en, rsp_valid}, 0);
        chk(cmd_ready == 1'b1, "R1", "ready", cmd_ready, 1);

        // Directed write/read mix, back to back
        issue(1'b1, 15'h0000, 8'h3C, 1'b0);
        issue(1'b0, 15'h0000, 8'h00, 1'b1);   // R8 gap after write
        issue(1'b1, 15'h7FFF, 8'hFF, 1'b1);   // R5 gap after read
        issue(1'b0, 15'h7FFF, 8'h00, 1'b1);
        issue(1'b0, 15'h1234, 8'h00, 1'b1);   // unwritten location
        issue(1'b1, 15'h1234, 8'h00, 1'b1);
        issue(1'b0, 15'h1234, 8'h00, 1'b1);
        issue(1'b1, 15'h1234, 8'h81, 1'b1);   // overwrite
        issue(1'b0, 15'h1234, 8'h00, 1'b1);

        // Patterned writes, then reads in reverse, some with idle gaps
        for (int i = 0; i < 12; i++) begin
            issue(1'b1, 15'((i * 2731) & 16'h7FFF), 8'(i * 29 + 7), 1'b0);
            if (i % 3 == 0) repeat (3) @(negedge clk);
        end
        for (int i = 11; i >= 0; i--) begin
            issue(1'b0, 15'((i * 2731) & 16'h7FFF), 8'h00, (i % 4) != 3);
            if (i % 4 == 3) repeat (2) @(negedge clk);
        end

        repeat (10) @(negedge clk);
        chk(rdq.size() == 0, "R9", "reads outstanding", rdq.size(), 0);
        chk(wrq.size() == 0, "R3", "writes outstanding", wrq.size(), 0);
        begin
            bit idle_ok;
            idle_ok = 1'b1;
            for (int k = 0; k < 5; k++) begin
                if (mem_ce_n !== 1'b1 || cmd_ready !== 1'b1) idle_ok = 1'b0;
                @(negedge clk);
            end
            chk(idle_ok, "R6", "standby while idle", idle_ok, 1);
        end
        chk(viol_r4 == 0, "R4", "drive/strobe conflicts", viol_r4, 0);
        chk(viol_r7 == 0, "R7", "address moved during access", viol_r7, 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule